// File: doc/BRIEF.md
# Ethernet Self-Test PRBS Frame Source

This block is a transmit-side self-test source for a byte-wide Ethernet datapath. It uses one byte clock. While enabled it sends frames back to back. Each frame is a fixed lead-in followed by pseudo-random payload bytes, and an idle gap separates one frame from the next. The output is a byte bus and a transmit-valid strobe in the GMII style. It also gives a flag that marks the delimiter-plus-payload span of each frame, and a count of completed frames.

Three register fields are inputs to the block:
- An 8-bit gap field. Each step of the field is four byte-times. Values below 12 are raised to 12. The surrounding register file resets this field to 125.
- A one-bit size select that picks a short or a long fixed payload.
- A 16-bit payload byte count. When it is nonzero it overrides the size select. The register file resets it to 1500.

The block takes all three values once, when a frame starts. That frame and the gap that follows it use those values.

The control is a state machine with five states:
- `ST_IDLE`: outputs quiet.
- `ST_PREAMBLE`: seven lead-in bytes.
- `ST_SFD`: the delimiter byte.
- `ST_PAYLOAD`: PRBS bytes.
- `ST_GAP`: the scaled idle gap.

It has these transitions:
- IDLE→PREAMBLE when enable is high.
- PREAMBLE→SFD after the seventh lead-in byte.
- SFD→PAYLOAD unconditionally.
- PAYLOAD→GAP after the last payload byte.
- GAP→PREAMBLE at the end of the gap if enable is high.
- GAP→IDLE at the end of the gap if enable is low.

A synchronous reset forces IDLE from any state.

Top module: `bist_frame_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters idle after that edge: `tx_en`=0, `txd`=0x00, `frame_active`=0, `frame_count`=0. The PRBS register is reseeded to all ones.
- R2: Every frame begins with exactly seven bytes of 0x55 and then one byte of 0xD5. `tx_en` rises on the first 0x55 byte.
- R3: The payload length in bytes is `prbs_len` when `prbs_len` is nonzero. When `prbs_len` is zero, it is 64 if `len_sel`=1 and 1518 if `len_sel`=0.
- R4: Payload bytes come from a 15-bit LFSR with polynomial x^15+x^14+1. Each new bit is state[14] XOR state[13], and it is shifted in at bit 0. Eight bits are produced per payload byte, and the first bit produced lands in `txd[0]`. The LFSR is seeded to all ones by reset and runs on across frames without reseeding.
- R5: After each payload, `tx_en` is low and `txd` is 0x00 for exactly 4×max(`gap_cfg`,12) clock cycles.
- R6: `frame_active` is high from the 0xD5 byte through the last payload byte and low at all other times.
- R7: `frame_count` increments by one in the first gap cycle after each completed payload. It changes at no other time except reset, and it wraps modulo 2^16.
- R8: `gap_cfg`, `len_sel` and `prbs_len` are sampled only in the cycle a frame starts. Changes during a frame or its gap affect only the next frame.
- R9: While `enable` is low from idle, no frame starts. Lowering `enable` mid-frame lets that frame and its gap complete, then the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run request for continuous frame generation |
| gap_cfg | input | 8 | Gap setting in units of four byte-times |
| len_sel | input | 1 | Fixed size select: 1 = 64-byte payload, 0 = 1518-byte payload |
| prbs_len | input | 16 | Payload byte count; nonzero overrides `len_sel` |
| txd | output | 8 | Transmit byte |
| tx_en | output | 1 | Transmit valid, preamble through last payload byte |
| frame_active | output | 1 | High from delimiter through last payload byte |
| frame_count | output | 16 | Completed frame count |

## Verification
The hardest situation to reach is a configuration change landing between frames. A wrong design could apply it to the gap in progress instead of the next frame. The stimulus table therefore loads the next row's settings in the first idle cycle after each payload, and then measures that gap against the previous row's expected length. The bench also covers a reset arriving inside a payload, which must reseed the PRBS, and an enable drop in mid-payload. Both are driven at chosen byte counts inside the frame rather than at frame boundaries.

// File: rtl/bist_gen_pkg.sv
package bist_gen_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_SFD,
        ST_PAYLOAD,
        ST_GAP
    } gen_state_t;

    localparam logic [7:0] LEAD_BYTE  = 8'h55;
    localparam logic [7:0] DELIM_BYTE = 8'hD5;

endpackage

// File: rtl/bist_len_resolve.sv
module bist_len_resolve #(
    parameter int GAP_W     = 8,
    parameter int LEN_W     = 16,
    parameter int OUT_W     = 16,
    parameter int GAP_SCALE = 4,
    parameter int GAP_MIN   = 12,
    parameter int SHORT_LEN = 64,
    parameter int LONG_LEN  = 1518
) (
    input  logic [GAP_W-1:0] gap_cfg,
    input  logic             len_sel,
    input  logic [LEN_W-1:0] prbs_len,
    output logic [OUT_W-1:0] payload_len,
    output logic [OUT_W-1:0] gap_len
);

    logic [GAP_W-1:0] gap_eff;

    always_comb begin
        gap_eff = (gap_cfg < GAP_W'(GAP_MIN)) ? GAP_W'(GAP_MIN) : gap_cfg;
        gap_len = OUT_W'(gap_eff) * OUT_W'(GAP_SCALE);
        if (prbs_len != '0)
            payload_len = OUT_W'(prbs_len);
        else if (len_sel)
            payload_len = OUT_W'(SHORT_LEN);
        else
            payload_len = OUT_W'(LONG_LEN);
    end

endmodule

// File: rtl/bist_prbs_byte.sv
module bist_prbs_byte #(
    parameter int PRBS_W = 15,
    parameter int TAP_A  = 14,
    parameter int TAP_B  = 13,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    output logic [BYTE_W-1:0] byte_out
);

    logic [PRBS_W-1:0] lfsr_q;
    logic [PRBS_W-1:0] stage [0:BYTE_W];

    assign stage[0] = lfsr_q;

    generate
        for (genvar i = 0; i < BYTE_W; i++) begin : g_step
            assign stage[i+1]  = {stage[i][PRBS_W-2:0], stage[i][TAP_A] ^ stage[i][TAP_B]};
            assign byte_out[i] = stage[i+1][0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            lfsr_q <= '1;
        else if (advance)
            lfsr_q <= stage[BYTE_W];
    end

    // R4: the register can never reach the all-zero lock-up state
    a_r4_no_lockup: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);

endmodule

// File: rtl/bist_frame_gen.sv
module bist_frame_gen
    import bist_gen_pkg::*;
#(
    parameter int GAP_W        = 8,
    parameter int LEN_W        = 16,
    parameter int FC_W         = 16,
    parameter int GAP_SCALE    = 4,
    parameter int GAP_MIN      = 12,
    parameter int SHORT_LEN    = 64,
    parameter int LONG_LEN     = 1518,
    parameter int PREAMBLE_LEN = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [GAP_W-1:0] gap_cfg,
    input  logic             len_sel,
    input  logic [LEN_W-1:0] prbs_len,
    output logic [7:0]       txd,
    output logic             tx_en,
    output logic             frame_active,
    output logic [FC_W-1:0]  frame_count
);

    localparam int GAP_MAX_CYC = ((1 << GAP_W) - 1) * GAP_SCALE;
    localparam int GAP_CW      = $clog2(GAP_MAX_CYC + 1);
    localparam int CNT_W       = (LEN_W > GAP_CW) ? LEN_W : GAP_CW;
    localparam int MIN_GAP_CYC = GAP_MIN * GAP_SCALE;

    gen_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] plen_q, glen_q;
    logic [CNT_W-1:0] payload_len, gap_len;
    logic [FC_W-1:0]  fc_q;
    logic [7:0]       prbs_byte;
    logic             prbs_adv;
    logic             start_frame;
    logic             end_payload;

    bist_len_resolve #(
        .GAP_W(GAP_W), .LEN_W(LEN_W), .OUT_W(CNT_W), .GAP_SCALE(GAP_SCALE),
        .GAP_MIN(GAP_MIN), .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)
    ) u_len (
        .gap_cfg    (gap_cfg),
        .len_sel    (len_sel),
        .prbs_len   (prbs_len),
        .payload_len(payload_len),
        .gap_len    (gap_len)
    );

    bist_prbs_byte #(.PRBS_W(15), .TAP_A(14), .TAP_B(13), .BYTE_W(8)) u_prbs (
        .clk     (clk),
        .rst     (rst),
        .advance (prbs_adv),
        .byte_out(prbs_byte)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (enable) state_d = ST_PREAMBLE;
            ST_PREAMBLE: if (cnt_q == CNT_W'(PREAMBLE_LEN - 1)) state_d = ST_SFD;
            ST_SFD:      state_d = ST_PAYLOAD;
            ST_PAYLOAD:  if (cnt_q == plen_q - CNT_W'(1)) state_d = ST_GAP;
            ST_GAP:      if (cnt_q == glen_q - CNT_W'(1))
                             state_d = enable ? ST_PREAMBLE : ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    assign start_frame = (state_d == ST_PREAMBLE) && (state_q != ST_PREAMBLE);
    assign end_payload = (state_q == ST_PAYLOAD) && (state_d == ST_GAP);

    // state register and counters
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            plen_q  <= '0;
            glen_q  <= '0;
            fc_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_d != state_q) ? '0 : cnt_q + CNT_W'(1);
            if (start_frame) begin
                plen_q <= payload_len;
                glen_q <= gap_len;
            end
            if (end_payload)
                fc_q <= fc_q + FC_W'(1);
        end
    end

    // outputs decoded from the current state
    always_comb begin
        txd          = 8'h00;
        tx_en        = 1'b0;
        frame_active = 1'b0;
        prbs_adv     = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_GAP: ;
            ST_PREAMBLE: begin
                txd   = LEAD_BYTE;
                tx_en = 1'b1;
            end
            ST_SFD: begin
                txd          = DELIM_BYTE;
                tx_en        = 1'b1;
                frame_active = 1'b1;
            end
            ST_PAYLOAD: begin
                txd          = prbs_byte;
                tx_en        = 1'b1;
                frame_active = 1'b1;
                prbs_adv     = 1'b1;
            end
            default: ;
        endcase
    end

    assign frame_count = fc_q;

    // R1: reset clears the outputs in the following cycle
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!tx_en && frame_count == '0));

    // R2: a frame always opens on a lead-in byte
    a_r2_lead_first: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_en) |-> txd == LEAD_BYTE);

    // R3: a latched payload length is never zero
    a_r3_len_nonzero: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PAYLOAD) |-> plen_q != '0);

    // R5: the latched gap never falls under the clamped minimum
    a_r5_gap_floor: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_GAP) |-> glen_q >= CNT_W'(MIN_GAP_CYC));

    // R6: the active flag lies inside the transmit window
    a_r6_active_in_frame: assert property (@(posedge clk) disable iff (rst)
        frame_active |-> tx_en);

    // R7: the count moves only by one, and exactly when a frame ends
    a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && frame_count != $past(frame_count))
            |-> frame_count == $past(frame_count) + FC_W'(1));
    a_r7_count_on_end: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(tx_en)) |-> frame_count == $past(frame_count) + FC_W'(1));

    // R9: idle with enable low stays quiet
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !enable) |=> !tx_en);

endmodule

// File: tb/bist_frame_gen_tb.sv
module bist_frame_gen_tb;

    localparam int CLK_P = 8;
    localparam int NV    = 7;
    localparam int IDLE_LIMIT = 2000;

    // stimulus rows: gap field, size select, byte count; expected payload and gap
    localparam int V_GAP [NV] = '{125, 12, 3, 0, 13, 255, 11};
    localparam int V_SEL [NV] = '{0, 0, 1, 1, 1, 0, 0};
    localparam int V_LEN [NV] = '{1500, 0, 0, 0, 5, 1, 70};
    localparam int E_LEN [NV] = '{1500, 1518, 64, 64, 5, 1, 70};
    localparam int E_GAP [NV] = '{500, 48, 48, 48, 52, 1020, 48};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [7:0]  gap_cfg = 8'd125;
    logic        len_sel = 1'b0;
    logic [15:0] prbs_len = 16'd1500;
    logic [7:0]  txd;
    logic        tx_en, frame_active;
    logic [15:0] frame_count;

    int n_chk = 0;
    int n_bad = 0;
    int fc_exp = 0;
    logic [14:0] m_lfsr = '1;

    always #(CLK_P/2) clk = ~clk;

    bist_frame_gen u_dut (
        .clk(clk), .rst(rst), .enable(enable), .gap_cfg(gap_cfg),
        .len_sel(len_sel), .prbs_len(prbs_len), .txd(txd), .tx_en(tx_en),
        .frame_active(frame_active), .frame_count(frame_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_byte();
        logic [7:0] b;
        for (int k = 0; k < 8; k++) begin
            logic nb;
            nb = m_lfsr[14] ^ m_lfsr[13];
            m_lfsr = {m_lfsr[13:0], nb};
            b[k] = nb;
        end
        return b;
    endfunction

    task automatic set_cfg(input int g, input int s, input int l);
        gap_cfg  = 8'(g);
        len_sel  = 1'(s);
        prbs_len = 16'(l);
    endtask

    // measure one frame; at gap start either load next row or drop enable
    task automatic run_frame(input int exp_len, input int exp_gap, input bit last,
                             input int drop_at, input int nxt);
        int w = 0;
        int pre = 0;
        int n = 0;
        int g = 0;
        int dbad = 0;
        int abad = 0;
        int zbad = 0;
        while (!tx_en && w < IDLE_LIMIT) begin
            w++;
            @(negedge clk);
        end
        chk(tx_en, "R2 frame start", int'(tx_en), 1);
        while (tx_en && txd == 8'h55 && pre < 20) begin
            if (frame_active) abad++;
            pre++;
            @(negedge clk);
        end
        chk(pre == 7 && abad == 0, "R2 lead-in bytes", pre, 7);
        chk(tx_en && txd == 8'hD5 && frame_active, "R2/R6 delimiter", int'(txd), 8'hD5);
        @(negedge clk);
        while (tx_en && n < exp_len + 5) begin
            if (txd != model_byte()) dbad++;
            if (!frame_active) abad++;
            n++;
            if (n == drop_at) enable = 1'b0;
            @(negedge clk);
        end
        chk(n == exp_len, "R3 payload length", n, exp_len);
        chk(dbad == 0, "R4 payload data", dbad, 0);
        chk(abad == 0 && !frame_active, "R6 active span", abad, 0);
        fc_exp++;
        chk(frame_count == 16'(fc_exp), "R7 frame count", int'(frame_count), fc_exp);
        if (last) enable = 1'b0;
        else if (nxt >= 0) set_cfg(V_GAP[nxt], V_SEL[nxt], V_LEN[nxt]);
        while (!tx_en && g < IDLE_LIMIT) begin
            if (txd != 8'h00 || frame_active) zbad++;
            g++;
            @(negedge clk);
        end
        chk(zbad == 0, "R5 gap quiet", zbad, 0);
        if (last)
            chk(g == IDLE_LIMIT && frame_count == 16'(fc_exp), "R9 stays idle", g, IDLE_LIMIT);
        else
            chk(g == exp_gap, "R5/R8 gap length", g, exp_gap);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int quiet = 0;
        repeat (3) @(negedge clk);
        chk(!tx_en && txd == 8'h00 && !frame_active && frame_count == 16'd0,
            "R1 reset state", int'(tx_en), 0);
        rst = 1'b0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (tx_en) quiet++;
        end
        chk(quiet == 0, "R9 no start while disabled", quiet, 0);

        // table walk: continuous frames, next row loaded at each gap start (R8)
        set_cfg(V_GAP[0], V_SEL[0], V_LEN[0]);
        enable = 1'b1;
        for (int i = 0; i < NV; i++)
            run_frame(E_LEN[i], E_GAP[i], (i == NV - 1), -1, (i < NV - 1) ? i + 1 : -1);

        // enable dropped in mid-payload: frame completes, then idle (R9)
        set_cfg(12, 1, 0);
        enable = 1'b1;
        run_frame(64, 48, 1'b1, 10, -1);

        // reset inside a payload reseeds the PRBS and clears the count (R1, R4)
        set_cfg(20, 0, 30);
        enable = 1'b1;
        while (!tx_en) @(negedge clk);
        repeat (15) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!tx_en && txd == 8'h00 && !frame_active && frame_count == 16'd0,
            "R1 reset mid-frame", int'(frame_count), 0);
        @(negedge clk);
        rst = 1'b0;
        m_lfsr = '1;
        fc_exp = 0;
        run_frame(30, 80, 1'b1, -1, -1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule